// File: doc/BRIEF.md
# Automatic Transmit/Receive Pin Switcher

This block drives several banks of general-purpose pins that lead to radio front-end boards. Every pin normally copies a bit from a software-owned output register, which arrives on `norm_out`. A pin can instead be placed under automatic control by setting its mask bit. An automatic pin then shows one of two programmed values. The transmit value is used while the block is in its transmit state, and the receive value is used otherwise.

The transmit state follows the level of `fifo_nonempty`, which is high while the transmit FIFO holds data. The rising edge and the falling edge each have their own programmable hold-off, counted in clock cycles. Front-end switches can therefore be settled before samples leave, and held until the last sample has drained. A pulse shorter than the programmed hold-off is filtered out.

One global enable bit turns automatic control on or off for all banks together. Writes go through a simple strobe, select, bank and data port. Register values cannot be read back.

Top module: `trx_pin_switch`

## Requirements
- R1: After reset, every register is zero and `tr_active` is 0. All pins therefore equal `norm_out`.
- R2: A pin whose mask bit is clear always equals the matching bit of `norm_out`.
- R3: With the enable bit set, a pin whose mask bit is set shows the transmit-value bit while `tr_active` is 1. It shows the receive-value bit while `tr_active` is 0.
- R4: While the enable bit (bit 0 of the control register) is 0, every pin equals `norm_out`, whatever the masks and values hold.
- R5: When `fifo_nonempty` goes from 0 to 1 and stays there, `tr_active` rises at the (TXD+1)-th rising clock edge that samples the new level. TXD is the transmit delay register, so a delay of 0 switches at the first such edge.
- R6: When `fifo_nonempty` goes from 1 to 0 and stays there, `tr_active` falls at the (RXD+1)-th rising clock edge that samples the new level. RXD is the receive delay register.
- R7: Each change of `fifo_nonempty` restarts the hold-off count. If the level returns to the value of `tr_active` before the delay has elapsed, `tr_active` does not change. `tr_active` only ever moves to the level that `fifo_nonempty` had at the previous edge.
- R8: A write occurs when `wr_en` is high at a rising edge, and it takes effect from that edge. The meaning of `wr_sel` is:
  - 0: mask of bank `wr_bank`
  - 1: transmit value of bank `wr_bank`
  - 2: receive value of bank `wr_bank`
  - 3: TXD, taken from `wr_data[11:0]`
  - 4: RXD, taken from `wr_data[11:0]`
  - 5: control register, enable in bit 0

  Codes 6 and 7 are ignored. A write to a bank register leaves the other banks unchanged.
- R9: Bank b occupies bits [16b+15:16b] of `pins`, of `norm_out` and of the bank's 16-bit registers. Bit i of a bank register governs pin i of that bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register selector (see R8) |
| wr_bank | input | 2 | Bank index for mask and value writes |
| wr_data | input | 16 | Write data |
| fifo_nonempty | input | 1 | High while the transmit FIFO holds data |
| norm_out | input | 64 | Normal output register bits, four banks of 16 |
| pins | output | 64 | Pin output values, four banks of 16 |
| tr_active | output | 1 | Delayed transmit/receive state |

## Verification
The assertions take for granted that `fifo_nonempty` and the write port are driven synchronously to `clk` and hold clean levels at every edge. They also assume `wr_bank` is always a valid bank index. The stimulus meets these conditions by changing every input only on the falling edge. It draws the bank index from the two low bits of a random word, so the index is always in range. In random rounds, the delays stay small and the bench waits longer than both delays before it compares pins. The directed delay tests measure exact switching edges and short pulses separately.

// File: rtl/trx_pin_switch.sv
module trx_pin_switch #(
  parameter int NBANK = 4,
  parameter int PW    = 16,
  parameter int DLYW  = 12,
  localparam int BW   = $clog2(NBANK),
  localparam int TOTW = NBANK * PW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [2:0]      wr_sel,
  input  logic [BW-1:0]   wr_bank,
  input  logic [PW-1:0]   wr_data,
  input  logic            fifo_nonempty,
  input  logic [TOTW-1:0] norm_out,
  output logic [TOTW-1:0] pins,
  output logic            tr_active
);

  logic [NBANK-1:0][PW-1:0] mask_q, txv_q, rxv_q;
  logic [DLYW-1:0] txd_q, rxd_q, cnt_q;
  logic            en_q, prev_q, stat_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q <= '0;
      txv_q  <= '0;
      rxv_q  <= '0;
      txd_q  <= '0;
      rxd_q  <= '0;
      en_q   <= 1'b0;
    end else if (wr_en) begin
      case (wr_sel)
        3'd0: mask_q[wr_bank] <= wr_data;
        3'd1: txv_q[wr_bank]  <= wr_data;
        3'd2: rxv_q[wr_bank]  <= wr_data;
        3'd3: txd_q <= wr_data[DLYW-1:0];
        3'd4: rxd_q <= wr_data[DLYW-1:0];
        3'd5: en_q  <= wr_data[0];
        default: ;
      endcase
    end
  end

  wire             edge_seen = fifo_nonempty != prev_q;
  wire [DLYW-1:0]  age       = edge_seen ? '0 : cnt_q;
  wire [DLYW-1:0]  need      = fifo_nonempty ? txd_q : rxd_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      cnt_q  <= '0;
      stat_q <= 1'b0;
    end else begin
      prev_q <= fifo_nonempty;
      if (edge_seen)
        cnt_q <= {{(DLYW-1){1'b0}}, 1'b1};
      else if (cnt_q != '1)
        cnt_q <= cnt_q + 1'b1;
      if (fifo_nonempty != stat_q && age >= need)
        stat_q <= fifo_nonempty;
    end
  end

  assign tr_active = stat_q;

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    wire [PW-1:0] nrm  = norm_out[b*PW +: PW];
    wire [PW-1:0] auto = stat_q ? txv_q[b] : rxv_q[b];
    wire [PW-1:0] m    = en_q ? mask_q[b] : '0;
    assign pins[b*PW +: PW] = (nrm & ~m) | (auto & m);
  end

endmodule

// File: rtl/trx_pin_switch_chk.sv
module trx_pin_switch_chk #(
  parameter int NBANK = 4,
  parameter int PW    = 16,
  localparam int BW   = $clog2(NBANK),
  localparam int TOTW = NBANK * PW
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     wr_en,
  input logic [2:0]               wr_sel,
  input logic [BW-1:0]            wr_bank,
  input logic [PW-1:0]            wr_data,
  input logic                     fifo_nonempty,
  input logic [TOTW-1:0]          norm_out,
  input logic [TOTW-1:0]          pins,
  input logic                     tr_active,
  input logic                     en_q,
  input logic [NBANK-1:0][PW-1:0] mask_q
);

  assert_unmasked_follow_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ((pins ^ norm_out) & ~TOTW'(mask_q)) == '0);

  assert_disabled_passthru_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |-> pins == norm_out);

  assert_moves_to_raw_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(tr_active) |-> tr_active == $past(fifo_nonempty));

  assert_settled_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
    tr_active == fifo_nonempty |=> $stable(tr_active));

  assert_mask_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_sel == 3'd0 |=> mask_q[$past(wr_bank)] == $past(wr_data));

endmodule

bind trx_pin_switch trx_pin_switch_chk #(.NBANK(NBANK), .PW(PW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_bank(wr_bank),
  .wr_data(wr_data), .fifo_nonempty(fifo_nonempty), .norm_out(norm_out),
  .pins(pins), .tr_active(tr_active), .en_q(en_q), .mask_q(mask_q)
);

// File: tb/tb_trx_pin_switch.sv
`timescale 1ns/1ps
module tb_trx_pin_switch;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_sel = '0;
  logic [1:0]  wr_bank = '0;
  logic [15:0] wr_data = '0;
  logic        fifo_nonempty = 1'b0;
  logic [63:0] norm_out = '0;
  logic [63:0] pins;
  logic        tr_active;

  int checks = 0, errors = 0;
  bit done = 0;

  logic [15:0] m_mask [4];
  logic [15:0] m_tx   [4];
  logic [15:0] m_rx   [4];
  logic        m_en;

  always #2 clk = ~clk;

  trx_pin_switch dut (.*);

  function automatic logic [63:0] exp_pins(input logic tr);
    logic [63:0] r;
    for (int b = 0; b < 4; b++) begin
      logic [15:0] n, m;
      n = norm_out[b*16 +: 16];
      m = m_en ? m_mask[b] : 16'h0;
      r[b*16 +: 16] = (n & ~m) | ((tr ? m_tx[b] : m_rx[b]) & m);
    end
    return r;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] s, input logic [1:0] b, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = s; wr_bank = b; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    if (s == 3'd0) m_mask[b] = d;
    if (s == 3'd1) m_tx[b] = d;
    if (s == 3'd2) m_rx[b] = d;
    if (s == 3'd5) m_en = d[0];
  endtask

  task automatic measure(input logic lvl, input int d, input string req);
    logic old;
    @(negedge clk);
    old = tr_active;
    fifo_nonempty = lvl;
    for (int j = 1; j <= d + 3; j++) begin
      @(negedge clk);
      chk(req, {63'd0, tr_active}, {63'd0, (j >= d + 1) ? lvl : old});
    end
  endtask

  initial begin
    #(4ns * 190000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    for (int b = 0; b < 4; b++) begin m_mask[b] = 0; m_tx[b] = 0; m_rx[b] = 0; end
    m_en = 0;
    norm_out = 64'hA5A5_0F0F_1234_FFFF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 tr", {63'd0, tr_active}, 64'd0);
    chk("R1 pins", pins, norm_out);

    // R4: masks and values loaded but enable off
    wr(3'd0, 2'd2, 16'hFFFF);
    wr(3'd1, 2'd2, 16'h00FF);
    wr(3'd2, 2'd2, 16'hF0F0);
    chk("R4 disabled", pins, norm_out);
    // R8: enable takes effect from the write edge
    @(negedge clk);
    wr_en = 1'b1; wr_sel = 3'd5; wr_data = 16'h0001;
    @(negedge clk);
    wr_en = 1'b0; m_en = 1'b1;
    chk("R8 next clock", pins, exp_pins(1'b0));
    // R9: bank 2 alone carries the receive value
    chk("R9 bank 2", pins, {norm_out[63:48], 16'hF0F0, norm_out[31:0]});
    // R8: ignored selector codes
    wr(3'd6, 2'd2, 16'h1234);
    wr(3'd7, 2'd0, 16'hFFFF);
    chk("R8 ignored codes", pins, exp_pins(1'b0));

    // R5/R6 delay timing
    wr(3'd3, 2'd0, 16'd0);
    wr(3'd4, 2'd0, 16'd0);
    measure(1'b1, 0, "R5 txd0");
    chk("R3 tx value", pins, exp_pins(1'b1));
    measure(1'b0, 0, "R6 rxd0");
    wr(3'd3, 2'd0, 16'd5);
    wr(3'd4, 2'd0, 16'hF007);
    measure(1'b1, 5, "R5 txd5");
    measure(1'b0, 7, "R6 rxd7");

    // R7: short pulses are filtered
    @(negedge clk); fifo_nonempty = 1'b1;
    repeat (3) @(negedge clk);
    fifo_nonempty = 1'b0;
    for (int j = 0; j < 10; j++) begin
      @(negedge clk);
      chk("R7 short rise", {63'd0, tr_active}, 64'd0);
    end
    wr(3'd3, 2'd0, 16'd0);
    measure(1'b1, 0, "R5 setup");
    @(negedge clk); fifo_nonempty = 1'b0;
    repeat (4) @(negedge clk);
    fifo_nonempty = 1'b1;
    repeat (2) @(negedge clk);
    fifo_nonempty = 1'b0;
    repeat (2) @(negedge clk);
    fifo_nonempty = 1'b1;
    for (int j = 0; j < 12; j++) begin
      @(negedge clk);
      chk("R7 restart", {63'd0, tr_active}, 64'd1);
    end

    // random rounds
    wr(3'd3, 2'd0, 16'd2);
    wr(3'd4, 2'd0, 16'd3);
    for (int it = 0; it < 60; it++) begin
      int unsigned r;
      r = $urandom;
      wr(3'($urandom % 3), 2'(r), 16'($urandom));
      if (r[8]) wr(3'd5, 2'd0, {15'd0, r[9] | r[10]});
      @(negedge clk);
      norm_out = {$urandom, $urandom};
      fifo_nonempty = r[12];
      repeat (6) @(negedge clk);
      chk("R5 R6 settle", {63'd0, tr_active}, {63'd0, fifo_nonempty});
      chk("R2 R3 R9 random", pins, exp_pins(fifo_nonempty));
    end

    // R4 with everything loaded: disable again
    wr(3'd5, 2'd0, 16'h0000);
    chk("R4 off again", pins, norm_out);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule